// File: doc/BRIEF.md
# Fetch Thread Selector with Predicted-Stall Gating

This block chooses which hardware thread of a multithreaded front end fetches in each cycle. It keeps a count of in-flight instructions for each thread. Among the threads allowed to fetch, the one with the smallest count gets the grant. When counts tie, a rotating pointer decides. The grant is a one-hot vector, derived combinationally from registered state, plus a valid bit.

A thread can also be excluded from fetch for a while. A memory-dependence predictor raises a request when one of the thread's loads is expected to wait on an older store whose address is not yet known. The request names the thread and gives the predicted wait. If the wait is below a threshold, the request is ignored.

If the wait meets the threshold, the thread is gated. It is let back in before the stall is over, at the point where the remaining predicted wait equals the front-end pipeline depth. This way its instructions reach the scheduler just as the stall clears. A stall-resolved strobe that arrives first lifts the gate at once.

Top module: `fetch_gate_sel`

## Requirements
- R1: When `grant_vld` is high, the granted thread has an in-flight count no larger than that of any other ungated thread. A count rises by one on a cycle with `inc` high and `dec` low for that thread. It falls by one on a cycle with `dec` high and `inc` low. It is unchanged when both are high or both are low.
- R2: Ties in count go to the first ungated thread found going upward from a rotating pointer, wrapping from thread NTHR-1 to thread 0. The pointer starts at thread 0 after reset. After each valid grant to thread t, the pointer moves to t+1, wrapping to 0.
- R3: An in-flight count stays at CNT_MAX when incremented there. It stays at 0 when decremented there.
- R4: A `gate_req` whose `gate_dly` is at least DLY_THRESH gates thread `gate_tid` from the next cycle on. A gated thread is never granted. A new qualifying request for an already gated thread restarts its timer.
- R5: A `gate_req` whose `gate_dly` is below DLY_THRESH has no effect on the thread's gate.
- R6: A thread gated with delay D takes part in selection again in the cycle that follows the D-FE_DEPTH-th clock edge after the edge that gated it. With D = 20 and FE_DEPTH = 5, it is gated for 15 cycles.
- R7: A `resolve` strobe for a thread clears its gate at the next edge. The exception is a qualifying `gate_req` for that same thread in the same cycle, which wins.
- R8: When every thread is gated, `grant` is all zeros and `grant_vld` is low.
- R9: `grant` has at most one bit set, and `grant_vld` equals the OR of its bits. Right after reset, all counts are 0, nothing is gated, and `grant` is 1 on thread 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc | input | NTHR | Per-thread strobe: one instruction entered the pipeline |
| dec | input | NTHR | Per-thread strobe: one instruction left the pipeline |
| gate_req | input | 1 | Predicted memory-dependence stall report |
| gate_tid | input | $clog2(NTHR) | Thread named by the stall report |
| gate_dly | input | DLY_W | Predicted stall length in cycles |
| resolve | input | NTHR | Per-thread strobe: the predicted stall has cleared |
| grant | output | NTHR | One-hot fetch grant |
| grant_vld | output | 1 | A thread is granted this cycle |

## Verification
The assertions check, on every cycle, the properties that hold at a single point in time:
- the grant is one-hot and agrees with its valid bit;
- no gated thread is granted;
- nothing is granted when every thread is gated;
- counts stay within their bound;
- the granted count is the minimum among eligible threads;
- the single-cycle effects of arming, short-request rejection and resolve.

The bench covers what only a sequence of cycles shows:
- the exact cycle of the early release after a long predicted stall;
- the order in which the rotating pointer breaks ties;
- counts that saturate and then drain, seen through which thread wins afterwards.

A cycle-level arithmetic model, written from the requirements, is compared against the grant over long pseudo-random runs.

// File: rtl/fgs_pkg.sv
package fgs_pkg;

   typedef enum logic [1:0] {
      CNT_HOLD = 2'd0,
      CNT_UP   = 2'd1,
      CNT_DOWN = 2'd2
   } cnt_op_e;

   // Opposing strobes in the same cycle cancel.
   function automatic cnt_op_e cnt_op(input logic up, input logic dn);
      if (up && !dn)      return CNT_UP;
      else if (dn && !up) return CNT_DOWN;
      else                return CNT_HOLD;
   endfunction

endpackage

// File: rtl/fgs_icount.sv
module fgs_icount
   import fgs_pkg::*;
#(
   parameter int CNT_MAX = 31,
   parameter int CNT_W   = $clog2(CNT_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up,
   input  logic             dn,
   output logic [CNT_W-1:0] cnt
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else begin
         case (cnt_op(up, dn))
            CNT_UP:   if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
            CNT_DOWN: if (cnt != '0) cnt <= cnt - 1'b1;
            default:  ;
         endcase
      end
   end

endmodule

// File: rtl/fgs_gate.sv
module fgs_gate #(
   parameter int DLY_W      = 8,
   parameter int FE_DEPTH   = 5,
   parameter int DLY_THRESH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DLY_W-1:0] dly,
   input  logic             resolve,
   output logic             held
);

   logic [DLY_W-1:0] tmr;
   logic             arm;

   // Short predicted stalls never gate.
   assign arm = load && (dly >= DLY_W'(DLY_THRESH));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held <= 1'b0;
         tmr  <= '0;
      end else if (arm) begin
         // Release ahead of stall end by the front-end depth.
         held <= 1'b1;
         tmr  <= dly - DLY_W'(FE_DEPTH);
      end else if (resolve) begin
         held <= 1'b0;
         tmr  <= '0;
      end else if (held) begin
         tmr <= tmr - 1'b1;
         if (tmr == DLY_W'(1)) held <= 1'b0;
      end
   end

endmodule

// File: rtl/fgs_pick.sv
module fgs_pick #(
   parameter int NTHR  = 4,
   parameter int CNT_W = 5,
   parameter int TID_W = $clog2(NTHR)
) (
   input  logic [NTHR-1:0]       elig,
   input  logic [NTHR*CNT_W-1:0] cnts,
   input  logic [TID_W-1:0]      start,
   output logic [NTHR-1:0]       onehot,
   output logic                  found,
   output logic [TID_W-1:0]      win
);

   logic [CNT_W-1:0] best;
   logic [CNT_W-1:0] cur;

   // Walk threads in rotation order from start; strict less-than keeps
   // the earliest thread in rotation order among equal counts.
   always_comb begin
      int idx;
      onehot = '0;
      found  = 1'b0;
      win    = '0;
      best   = '0;
      cur    = '0;
      for (int k = 0; k < NTHR; k++) begin
         idx = int'(start) + k;
         if (idx >= NTHR) idx = idx - NTHR;
         cur = cnts[idx*CNT_W +: CNT_W];
         if (elig[idx] && (!found || cur < best)) begin
            found = 1'b1;
            best  = cur;
            win   = TID_W'(idx);
         end
      end
      if (found) onehot[win] = 1'b1;
   end

endmodule

// File: rtl/fetch_gate_sel.sv
module fetch_gate_sel
   import fgs_pkg::*;
#(
   parameter int NTHR        = 4,
   parameter int CNT_MAX     = 31,
   parameter int DLY_W       = 8,
   parameter int FE_DEPTH    = 5,
   parameter int DLY_THRESH  = 8,
   parameter int ROTATE_TIES = 1,
   localparam int TID_W      = $clog2(NTHR),
   localparam int CNT_W      = $clog2(CNT_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NTHR-1:0]  inc,
   input  logic [NTHR-1:0]  dec,
   input  logic             gate_req,
   input  logic [TID_W-1:0] gate_tid,
   input  logic [DLY_W-1:0] gate_dly,
   input  logic [NTHR-1:0]  resolve,
   output logic [NTHR-1:0]  grant,
   output logic             grant_vld
);

   if (NTHR < 2)                      $error("NTHR must be at least 2");
   if (CNT_MAX < 1)                   $error("CNT_MAX must be at least 1");
   if (DLY_THRESH <= FE_DEPTH)        $error("DLY_THRESH must exceed FE_DEPTH");
   if (DLY_THRESH >= (1 << DLY_W))    $error("DLY_THRESH does not fit DLY_W");

   logic [NTHR*CNT_W-1:0] cnt_flat;
   logic [NTHR-1:0]       gate_q;
   logic [TID_W-1:0]      rr_q;
   logic [TID_W-1:0]      win;
   logic                  found;

   for (genvar t = 0; t < NTHR; t++) begin : g_thr
      fgs_icount #(.CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .up    (inc[t]),
         .dn    (dec[t]),
         .cnt   (cnt_flat[t*CNT_W +: CNT_W])
      );

      fgs_gate #(.DLY_W(DLY_W), .FE_DEPTH(FE_DEPTH), .DLY_THRESH(DLY_THRESH)) u_gate (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (gate_req && (gate_tid == TID_W'(t))),
         .dly     (gate_dly),
         .resolve (resolve[t]),
         .held    (gate_q[t])
      );
   end

   fgs_pick #(.NTHR(NTHR), .CNT_W(CNT_W), .TID_W(TID_W)) u_pick (
      .elig   (~gate_q),
      .cnts   (cnt_flat),
      .start  (rr_q),
      .onehot (grant),
      .found  (found),
      .win    (win)
   );

   assign grant_vld = found;

   if (ROTATE_TIES != 0) begin : g_rotate
      always_ff @(posedge clk) begin
         if (!rst_n)     rr_q <= '0;
         else if (found) rr_q <= (win == TID_W'(NTHR - 1)) ? '0 : win + 1'b1;
      end
   end else begin : g_fixed
      assign rr_q = '0;
   end

endmodule

// File: rtl/fgs_checker.sv
module fgs_checker #(
   parameter int NTHR       = 4,
   parameter int CNT_MAX    = 31,
   parameter int DLY_W      = 8,
   parameter int DLY_THRESH = 8,
   localparam int TID_W     = $clog2(NTHR),
   localparam int CNT_W     = $clog2(CNT_MAX + 1)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  gate_req,
   input logic [TID_W-1:0]      gate_tid,
   input logic [DLY_W-1:0]      gate_dly,
   input logic [NTHR-1:0]       resolve,
   input logic [NTHR-1:0]       grant,
   input logic                  grant_vld,
   input logic [NTHR-1:0]       gate_q,
   input logic [NTHR*CNT_W-1:0] cnt_flat
);

   logic             long_req;
   logic [CNT_W-1:0] wc;
   logic             min_ok;

   assign long_req = gate_req && (gate_dly >= DLY_W'(DLY_THRESH));

   always_comb begin
      wc     = '0;
      min_ok = 1'b1;
      for (int u = 0; u < NTHR; u++)
         if (grant[u]) wc = cnt_flat[u*CNT_W +: CNT_W];
      for (int u = 0; u < NTHR; u++)
         if (!gate_q[u] && cnt_flat[u*CNT_W +: CNT_W] < wc) min_ok = 1'b0;
   end

   p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && (grant_vld == (grant != '0)));

   p_min_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
      grant_vld |-> min_ok);

   p_gated_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & gate_q) == '0);

   p_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
      long_req |=> gate_q[$past(gate_tid)]);

   p_short_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_req && !long_req && !gate_q[gate_tid]) |=> !gate_q[$past(gate_tid)]);

   p_all_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (&gate_q) |-> !grant_vld);

   for (genvar t = 0; t < NTHR; t++) begin : g_per
      p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_flat[t*CNT_W +: CNT_W] <= CNT_W'(CNT_MAX));

      p_resolve_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (resolve[t] && !(long_req && gate_tid == TID_W'(t))) |=> !gate_q[t]);
   end

endmodule

bind fetch_gate_sel fgs_checker #(
   .NTHR(NTHR), .CNT_MAX(CNT_MAX), .DLY_W(DLY_W), .DLY_THRESH(DLY_THRESH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .gate_req  (gate_req),
   .gate_tid  (gate_tid),
   .gate_dly  (gate_dly),
   .resolve   (resolve),
   .grant     (grant),
   .grant_vld (grant_vld),
   .gate_q    (gate_q),
   .cnt_flat  (cnt_flat)
);

// File: tb/fetch_gate_sel_test.sv
`timescale 1ns/1ps
module fetch_gate_sel_test;

   localparam int N   = 4;
   localparam int MX  = 7;
   localparam int DW  = 6;
   localparam int FE  = 5;
   localparam int TH  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  inc = '0, dec = '0, resolve = '0;
   logic          gate_req = 1'b0;
   logic [1:0]    gate_tid = '0;
   logic [DW-1:0] gate_dly = '0;
   logic [N-1:0]  grant;
   logic          grant_vld;

   int checks = 0;
   int fails  = 0;

   int mcnt[N];
   int mtim[N];
   bit mg[N];
   int mptr;

   always #5 clk = ~clk;

   fetch_gate_sel #(.NTHR(N), .CNT_MAX(MX), .DLY_W(DW), .FE_DEPTH(FE),
                    .DLY_THRESH(TH), .ROTATE_TIES(1)) uut (
      .clk(clk), .rst_n(rst_n), .inc(inc), .dec(dec), .gate_req(gate_req),
      .gate_tid(gate_tid), .gate_dly(gate_dly), .resolve(resolve),
      .grant(grant), .grant_vld(grant_vld));

   function automatic void model_pick(output logic [N-1:0] g, output bit v, output int w);
      int best = 0;
      g = '0; v = 0; w = 0;
      for (int k = 0; k < N; k++) begin
         int idx = (mptr + k) % N;
         if (!mg[idx] && (!v || mcnt[idx] < best)) begin
            v = 1; best = mcnt[idx]; w = idx;
         end
      end
      if (v) g[w] = 1'b1;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_model(input string tag);
      logic [N-1:0] eg; bit ev; int ew;
      model_pick(eg, ev, ew);
      chk(grant === eg && grant_vld === ev, tag, {grant_vld, grant}, {ev, eg});
   endtask

   // Drive one cycle of inputs, advance the model across the edge, then check.
   task automatic step(input logic [N-1:0] i, input logic [N-1:0] d, input logic rq,
                       input int tid, input int dl, input logic [N-1:0] rs, input string tag);
      logic [N-1:0] eg; bit ev; int ew;
      model_pick(eg, ev, ew);
      inc = i; dec = d; gate_req = rq; gate_tid = 2'(tid); gate_dly = DW'(dl); resolve = rs;
      @(posedge clk);
      if (ev) mptr = (ew + 1) % N;
      for (int t = 0; t < N; t++) begin
         if (i[t] && !d[t] && mcnt[t] < MX) mcnt[t]++;
         else if (d[t] && !i[t] && mcnt[t] > 0) mcnt[t]--;
         if (rq && tid == t && dl >= TH) begin
            mg[t] = 1; mtim[t] = dl - FE;
         end else if (rs[t]) begin
            mg[t] = 0; mtim[t] = 0;
         end else if (mg[t]) begin
            if (mtim[t] == 1) mg[t] = 0;
            mtim[t]--;
         end
      end
      @(negedge clk);
      inc = '0; dec = '0; gate_req = 1'b0; resolve = '0;
      check_model(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int seed = 32'h1d2c3b4a;
      for (int t = 0; t < N; t++) begin mcnt[t] = 0; mtim[t] = 0; mg[t] = 0; end
      mptr = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R9: reset state
      chk(grant === 4'b0001 && grant_vld === 1'b1, "R9 reset", {grant_vld, grant}, 5'h11);

      // R2: idle ties rotate 1,2,3,0,1
      for (int k = 0; k < 5; k++) begin
         step('0, '0, 0, 0, 0, '0, "R2");
         chk(grant === 4'(1 << ((k + 1) % N)), "R2 rotation", grant, 1 << ((k + 1) % N));
      end

      // R3: saturate thread 0, then drain past zero
      for (int k = 0; k < 10; k++) step(4'b0001, '0, 0, 0, 0, '0, "R3 up");
      for (int k = 0; k < 7; k++) step('0, 4'b0001, 0, 0, 0, '0, "R3 down");
      chk(grant === 4'b0001 || mptr != 0, "R3 drained", grant, 1);
      for (int k = 0; k < 4; k++) step('0, 4'b1000, 0, 0, 0, '0, "R3 underflow");
      step(4'b0111, '0, 0, 0, 0, '0, "R3 floor");
      chk(grant === 4'b1000, "R3 floor", grant, 4'b1000);

      // R1: count ordering
      step(4'b1000, '0, 0, 0, 0, '0, "R1");
      step(4'b1000, '0, 0, 0, 0, '0, "R1");
      step(4'b0011, 4'b0000, 0, 0, 0, '0, "R1");
      chk(grant === 4'b0100, "R1 fewest", grant, 4'b0100);

      // R5: short stall ignored
      step('0, '0, 1, 2, TH - 1, '0, "R5");
      chk(grant === 4'b0100, "R5 ungated", grant, 4'b0100);

      // R4, R8, R6, R7
      step('0, '0, 1, 0, 60, '0, "R4");
      step('0, '0, 1, 1, 60, '0, "R4");
      step('0, '0, 1, 3, 60, '0, "R4");
      chk(grant === 4'b0100, "R4 only ungated", grant, 4'b0100);
      step('0, '0, 1, 2, 20, '0, "R8");
      chk(grant === 4'b0000 && grant_vld === 1'b0, "R8 all gated", {grant_vld, grant}, 0);
      for (int k = 0; k < 14; k++) step('0, '0, 0, 0, 0, '0, "R6 hold");
      chk(grant_vld === 1'b0, "R6 still gated", grant_vld, 0);
      step('0, '0, 0, 0, 0, '0, "R6 release");
      chk(grant === 4'b0100, "R6 release", grant, 4'b0100);
      step('0, '0, 0, 0, 0, 4'b0001, "R7");
      chk(grant[0] === 1'b1 || grant[2] === 1'b1, "R7 resolved", grant, 1);
      step('0, '0, 1, 1, 30, 4'b0010, "R7 gate wins");
      chk(grant[1] === 1'b0, "R7 gate wins", grant, 0);
      step('0, '0, 0, 0, 0, 4'b1111, "R7 clear");
      chk(grant_vld === 1'b1, "R7 clear", grant_vld, 1);

      // R1/R2/R4/R6: pseudo-random sweep against the model
      for (int k = 0; k < 4000; k++) begin
         logic [N-1:0] ri, rd, rr; logic rq; int rt, rdl;
         seed ^= seed << 13; seed ^= seed >>> 17; seed ^= seed << 5;
         ri = seed[3:0]; rd = seed[7:4];
         rq = (seed[10:9] == 2'b00);
         rt = int'(seed[12:11]);
         rdl = int'(seed[18:13]) % 40;
         rr = (seed[22:20] == 3'b000) ? seed[26:23] : '0;
         step(ri, rd, rq, rt, rdl, rr, "R1 sweep");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule